// File: doc/BRIEF.md
# Asymmetric Three-Way Decode Steering

This block sits between instruction pre-classification and a row of three instruction decoders. Each cycle it sees up to three instructions in slot order, each one tagged with the number of micro-ops it expands to. It decides how many of them enter decode in this cycle and which decoder lane takes each one. The lanes are not equal. Lane 0 can expand an instruction into as many as four micro-ops. Lanes 1 and 2 only turn out one micro-op each. A group therefore follows a 4-1-1 shape. The group is cut short as soon as a later slot holds a multi-micro-op instruction, and that instruction becomes slot 0 of the next group.

Some instructions expand beyond what lane 0 can produce. Such an instruction is handed to a microcode sequencer instead of a decoder. The block pulses a start signal for it, counts it as consumed, and then holds off all decode until the sequencer reports completion. The front end uses the accepted count to advance its instruction queue. Typical cases: a register-memory add takes two micro-ops, a memory-destination add takes four, and a plain store takes two. All of them can only go to lane 0.

Top module: `trio_decode_steer`

## Requirements
- R1: After reset the sequencer is idle (`seq_busy`=0). With no valid slot, `take_cnt`=0, `lane_vld`=0, every `lane_uops` field is 0 and `seq_start`=0.
- R2: When idle, a valid slot 0 whose count is 1 to MAX_CPLX (default 4) goes to lane 0. `lane_vld[0]`=1 and lane 0's field carries that count.
- R3: Slot i (i≥1) goes to lane i only if every earlier slot went to a lane and slot i's count is 1. The first slot whose count is 2 or more ends the group before that slot.
- R4: A slot with its `slot_vld` bit at 0 ends the group. No later slot is accepted in that cycle, even if it is valid.
- R5: When idle, a valid slot 0 whose count exceeds MAX_CPLX raises `seq_start` for that cycle with `take_cnt`=1 and no lane valid. `seq_busy` is 1 from the next cycle.
- R6: While `seq_busy`=1, `take_cnt`=0, `lane_vld`=0 and `seq_start`=0. A `seq_done` pulse clears `seq_busy` at the next edge, and acceptance resumes in the cycle after that.
- R7: `seq_done` while `seq_busy`=0 has no effect.
- R8: A lane that is not valid drives a zero count. The lane counts sum to at most MAX_CPLX+NUM_DEC-1 (6 by default).
- R9: `take_cnt` equals the number of valid lanes plus `seq_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_vld | input | 3 | Valid bit per slot, bit i for slot i |
| slot_uops | input | 12 | Micro-op count per slot, slot i at bits [4i+3:4i] |
| seq_done | input | 1 | Microcode sequencer has finished |
| take_cnt | output | 2 | Instructions consumed this cycle |
| lane_vld | output | 3 | Decoder lane i busy with an instruction |
| lane_uops | output | 12 | Micro-op count per lane, lane i at bits [4i+3:4i] |
| seq_start | output | 1 | Launch the microcode sequencer |
| seq_busy | output | 1 | Sequencer running, decode stalled |

## Verification
The only state is the sequencer-busy flag. If it goes wrong, the effect shows up at the ports in the same cycle. A flag that sticks high shows as zero `take_cnt` where a group should form. A flag that is lost lets lanes go valid and `seq_start` fire in the cycles that should be stalled. A group-cutting error shows at once as a wrong `take_cnt` or a wrong lane count for that input pattern. A lane count passed through for an invalid lane breaks the zero-count and sum rules in the same cycle.

// File: rtl/trio_dec_pkg.sv
package trio_dec_pkg;
   // class of one incoming slot as seen by the steering logic
   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_SIMPLE = 2'd1,
      CLS_MULTI  = 2'd2,
      CLS_UCODE  = 2'd3
   } slot_cls_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/trio_slot_classify.sv
module trio_slot_classify
   import trio_dec_pkg::*;
#(
   parameter int unsigned UOP_W    = 4,
   parameter int unsigned MAX_CPLX = 4
) (
   input  logic             vld,
   input  logic [UOP_W-1:0] uops,
   output slot_cls_e        cls
);
   localparam logic [UOP_W-1:0] CPLX_LIM = UOP_W'(MAX_CPLX);

   always_comb begin
      if (!vld)                   cls = CLS_NONE;
      else if (uops <= 1)         cls = CLS_SIMPLE;
      else if (uops <= CPLX_LIM)  cls = CLS_MULTI;
      else                        cls = CLS_UCODE;
   end
endmodule

// File: rtl/trio_group_form.sv
module trio_group_form
   import trio_dec_pkg::*;
#(
   parameter int unsigned NUM_DEC = 3,
   parameter int unsigned UOP_W   = 4,
   localparam int unsigned TAKE_W = cnt_width(NUM_DEC)
) (
   input  slot_cls_e [NUM_DEC-1:0]       cls,
   input  logic [NUM_DEC*UOP_W-1:0]      uops,
   input  logic                          busy,
   output logic [NUM_DEC-1:0]            lane_vld,
   output logic [NUM_DEC*UOP_W-1:0]      lane_uops,
   output logic [TAKE_W-1:0]             take_cnt,
   output logic                          seq_start
);
   logic [NUM_DEC-1:0] chain;

   // lane 0 is the only lane able to expand a multi-micro-op instruction
   assign chain[0]  = !busy && ((cls[0] == CLS_SIMPLE) || (cls[0] == CLS_MULTI));
   assign seq_start = !busy && (cls[0] == CLS_UCODE);

   for (genvar i = 1; i < NUM_DEC; i++) begin : g_tail
      assign chain[i] = chain[i-1] && (cls[i] == CLS_SIMPLE);
   end

   for (genvar i = 0; i < NUM_DEC; i++) begin : g_lane
      assign lane_uops[i*UOP_W +: UOP_W] = chain[i] ? uops[i*UOP_W +: UOP_W] : '0;
   end

   assign lane_vld = chain;

   always_comb begin
      take_cnt = TAKE_W'(seq_start);
      for (int i = 0; i < NUM_DEC; i++)
         take_cnt = take_cnt + TAKE_W'(chain[i]);
   end
endmodule

// File: rtl/trio_seq_track.sv
module trio_seq_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy <= 1'b0;
      else if (busy && done) busy <= 1'b0;
      else if (start)        busy <= 1'b1;
   end

   assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy);
   assert_idle_done_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && done && !start) |=> !busy);
endmodule

// File: rtl/trio_decode_steer.sv
module trio_decode_steer
   import trio_dec_pkg::*;
#(
   parameter int unsigned NUM_DEC  = 3,
   parameter int unsigned UOP_W    = 4,
   parameter int unsigned MAX_CPLX = 4,
   localparam int unsigned TAKE_W  = cnt_width(NUM_DEC),
   localparam int unsigned PEAK    = MAX_CPLX + NUM_DEC - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_DEC-1:0]       slot_vld,
   input  logic [NUM_DEC*UOP_W-1:0] slot_uops,
   input  logic                     seq_done,
   output logic [TAKE_W-1:0]        take_cnt,
   output logic [NUM_DEC-1:0]       lane_vld,
   output logic [NUM_DEC*UOP_W-1:0] lane_uops,
   output logic                     seq_start,
   output logic                     seq_busy
);
   if (NUM_DEC < 1) begin : g_bad_dec
      $error("NUM_DEC must be at least 1");
   end
   if (MAX_CPLX < 1 || MAX_CPLX >= (1 << UOP_W) - 1) begin : g_bad_cplx
      $error("MAX_CPLX must lie in 1 .. 2**UOP_W-2");
   end

   slot_cls_e [NUM_DEC-1:0] cls;

   for (genvar i = 0; i < NUM_DEC; i++) begin : g_cls
      trio_slot_classify #(.UOP_W(UOP_W), .MAX_CPLX(MAX_CPLX)) u_cls (
         .vld  (slot_vld[i]),
         .uops (slot_uops[i*UOP_W +: UOP_W]),
         .cls  (cls[i])
      );
   end

   trio_group_form #(.NUM_DEC(NUM_DEC), .UOP_W(UOP_W)) u_form (
      .cls       (cls),
      .uops      (slot_uops),
      .busy      (seq_busy),
      .lane_vld  (lane_vld),
      .lane_uops (lane_uops),
      .take_cnt  (take_cnt),
      .seq_start (seq_start)
   );

   trio_seq_track u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .start (seq_start),
      .done  (seq_done),
      .busy  (seq_busy)
   );

   int unsigned lane_sum;
   always_comb begin
      lane_sum = 0;
      for (int i = 0; i < NUM_DEC; i++)
         lane_sum = lane_sum + int'(lane_uops[i*UOP_W +: UOP_W]);
   end

   assert_lane_peak_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lane_sum <= PEAK);
   assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> (lane_vld == '0 && take_cnt == '0 && !seq_start));
   assert_start_no_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> (lane_vld == '0 && take_cnt == TAKE_W'(1)));
   assert_lane0_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld[0] |-> (slot_vld[0] && lane_uops[0 +: UOP_W] <= UOP_W'(MAX_CPLX)));

   for (genvar i = 1; i < NUM_DEC; i++) begin : g_chk
      assert_tail_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
         lane_vld[i] |-> (lane_vld[i-1] && lane_uops[i*UOP_W +: UOP_W] == UOP_W'(1)));
      assert_gap_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !slot_vld[i-1] |-> !lane_vld[i]);
   end
   for (genvar i = 0; i < NUM_DEC; i++) begin : g_zero
      assert_idle_lane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_vld[i] |-> (lane_uops[i*UOP_W +: UOP_W] == '0));
   end
endmodule

// File: tb/trio_decode_steer_bench.sv
module trio_decode_steer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  slot_vld = '0;
   logic [11:0] slot_uops = '0;
   logic        seq_done = 1'b0;
   logic [1:0]  take_cnt;
   logic [2:0]  lane_vld;
   logic [11:0] lane_uops;
   logic        seq_start;
   logic        seq_busy;

   int n_cmp = 0;
   int n_bad = 0;
   bit m_busy = 1'b0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   trio_decode_steer u_trio_decode_steer (
      .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_uops(slot_uops),
      .seq_done(seq_done), .take_cnt(take_cnt), .lane_vld(lane_vld),
      .lane_uops(lane_uops), .seq_start(seq_start), .seq_busy(seq_busy)
   );

   // expected outputs packed as {take, lane_vld, lane_uops, start, busy}
   function automatic logic [18:0] expect_out(input bit busy, input logic [2:0] v,
                                              input logic [11:0] u);
      logic [1:0]  tk = 0;
      logic [2:0]  lv = 0;
      logic [11:0] lu = 0;
      logic        st = 0;
      if (!busy && v[0]) begin
         if (u[3:0] > 4) begin
            st = 1; tk = 1;
         end else begin
            lv[0] = 1; lu[3:0] = u[3:0]; tk = 1;
            for (int k = 1; k < 3; k++) begin
               if (lv[k-1] && v[k] && u[k*4 +: 4] == 4'd1) begin
                  lv[k] = 1; lu[k*4 +: 4] = 4'd1; tk = tk + 1;
               end
            end
         end
      end
      return {tk, lv, lu, st, busy};
   endfunction

   task automatic step(input logic [2:0] v, input logic [3:0] u0, input logic [3:0] u1,
                       input logic [3:0] u2, input logic done, input string req);
      logic [18:0] exp_v, act_v;
      @(negedge clk);
      slot_vld = v; slot_uops = {u2, u1, u0}; seq_done = done;
      #2;
      exp_v = expect_out(m_busy, v, {u2, u1, u0});
      act_v = {take_cnt, lane_vld, lane_uops, seq_start, seq_busy};
      n_cmp++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s: {take,lvld,luops,start,busy} actual=%h expected=%h", req, act_v, exp_v);
      end
      @(posedge clk);
      if (m_busy && done) m_busy = 1'b0;
      else if (exp_v[1]) m_busy = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step(3'b000, 0, 0, 0, 0, "R1 reset idle");
      step(3'b111, 4, 1, 1, 0, "R2 R8 R9 full 4-1-1 group");
      step(3'b111, 1, 1, 1, 0, "R3 all simple");
      step(3'b111, 1, 2, 1, 0, "R3 multi in slot1 cuts");
      step(3'b111, 2, 1, 3, 0, "R3 multi in slot2 cuts");
      step(3'b101, 1, 1, 1, 0, "R4 gap ends group");
      step(3'b110, 1, 1, 1, 0, "R4 empty slot0");
      step(3'b001, 4, 0, 0, 1, "R7 done while idle");
      step(3'b001, 4, 0, 0, 0, "R7 still idle after stray done");
      step(3'b111, 5, 1, 1, 0, "R5 boundary ucode start");
      step(3'b111, 1, 1, 1, 0, "R6 stalled");
      step(3'b111, 2, 1, 1, 1, "R6 done while stalled");
      step(3'b111, 2, 1, 1, 0, "R6 resumed");
      step(3'b011, 15, 1, 1, 0, "R5 max count to sequencer");
      step(3'b001, 1, 0, 0, 1, "R6 done again");
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] v;
         logic [3:0] uu [3];
         string tag;
         v = 3'($urandom_range(0, 7));
         for (int k = 0; k < 3; k++) begin
            int r = $urandom_range(0, 99);
            uu[k] = (r < 60) ? 4'd1 : (r < 85) ? 4'($urandom_range(2, 4))
                                               : 4'($urandom_range(5, 12));
         end
         tag = m_busy ? "R6 random stall" : (v[0] && uu[0] > 4) ? "R5 random ucode"
                                                              : "R3 R9 random group";
         step(v, uu[0], uu[1], uu[2], ($urandom_range(0, 3) == 0), tag);
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule